// File: doc/BRIEF.md
# Pixel-Doubling Framebuffer Writer

This block sits between a pixel renderer and a display framebuffer. It takes a stream of rendered pixels for a small source picture and stores each one in a larger linear framebuffer. The framebuffer holds one 32-bit RGB word per pixel. Each source pixel is scaled by two in both directions. The scaled picture is placed at a fixed column offset, so it sits centred inside the visible display area.

After reset, the block first fills every framebuffer word with black, one word per cycle. Only then does it accept pixels. Each accepted pixel becomes four single-cycle writes on a plain memory write port: two writes side by side on the upper output row, then the same pair on the row below. A start-of-frame flag and an end-of-line flag on the input stream keep the source position in step. Pixels that fall outside the source picture are taken from the stream and discarded without any write.

With the default parameters, the source picture is 256x240. It is scaled to 512x480 and starts at display column 64, inside a 640x480 visible area of a framebuffer with a 1024-word line stride and 512 lines.

Top module: `pixdbl_fb_writer`

## Requirements
- R1: After reset is released, the block writes the value 0 (black) to every framebuffer address, in ascending order from 0 to LINE_STRIDE*FB_LINES-1, one address per cycle and with no gaps.
- R2: `in_ready` stays low until the cycle after the write to the last framebuffer address. No pixel is accepted before then.
- R3: A pixel accepted at a rising edge produces four writes of its `in_rgb` value on the next four cycles. With source position (sx, sy), the writes go to output pixels (2sx, 2sy), (2sx+1, 2sy), (2sx, 2sy+1) and (2sx+1, 2sy+1), in that order.
- R4: Output pixel (x, y) is stored at address y*LINE_STRIDE + H_OFFSET + x.
- R5: `in_ready` is low during the first three writes of a pixel and high during the fourth. A new pixel offered in that fourth cycle is accepted, so pixels can be taken one every four cycles.
- R6: A pixel with `in_sof` set is placed at source position (0, 0), whatever the previous position was.
- R7: After a pixel with `in_eol` set, the next pixel goes to column 0 of the next source row. Otherwise the column advances by one.
- R8: A pixel whose source row is SRC_H or beyond is accepted in a single cycle and produces no write. The row count stops at SRC_H.
- R9: A pixel whose source column is SRC_W or beyond is accepted in a single cycle and produces no write. An end-of-line on such a pixel still moves the position to the next row.
- R10: Once the clear has finished, `wr_en` is low in every cycle that is not one of the four writes of an accepted pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts the clear |
| in_valid | input | 1 | A pixel is offered on the input stream |
| in_ready | output | 1 | The block takes the offered pixel at this edge |
| in_sof | input | 1 | The offered pixel is the first of a frame |
| in_eol | input | 1 | The offered pixel is the last of its source line |
| in_rgb | input | DATA_W | RGB value of the offered pixel |
| wr_en | output | 1 | A framebuffer write is made this cycle |
| wr_addr | output | $clog2(LINE_STRIDE*FB_LINES) | Framebuffer word address |
| wr_data | output | DATA_W | Framebuffer write data |

## Verification
Most internal faults show up as a wrong address at the write port, within at most four cycles of the pixel that exposes them:

- A stuck or mis-stepped quad phase shows as a repeated or missing address inside one group of four writes.
- A wrong row stride or doubling shifts the third and fourth writes.
- A column or row counter that slips is visible on the first write after the end-of-line or start-of-frame pixel that should have corrected it.

Two other kinds of fault take longer to see:

- A fault in the clear counter changes the address sequence within the first clear cycles. A wrong end-of-clear decision moves the rise of `in_ready` away from exactly LINE_STRIDE*FB_LINES cycles after reset.
- A faulty drop decision shows either as writes where none should appear, or as a missing write in the cycle right after the pixel is accepted.

// File: rtl/pdfb_pkg.sv
package pdfb_pkg;

   // Order of the four framebuffer writes issued for one source pixel.
   // Bit 1 selects the lower output row, bit 0 the right-hand column.
   typedef enum logic [1:0] {
      Q_TL = 2'd0,
      Q_TR = 2'd1,
      Q_BL = 2'd2,
      Q_BR = 2'd3
   } quad_e;

endpackage

// File: rtl/pdfb_clear_seq.sv
module pdfb_clear_seq #(
   parameter int DEPTH = 1024*512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          clr_done,
   output logic [AW-1:0] clr_addr
);

   logic [AW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == AW'(DEPTH-1))
            done_q <= 1'b1;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign clr_done = done_q;
   assign clr_addr = cnt_q;

   // R1: the clear walks the addresses one step per cycle until it ends
   assert_clear_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |=> (done_q || cnt_q == $past(cnt_q) + 1'b1));

   // R1: once finished, the clear never restarts without a reset
   assert_clear_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);

endmodule

// File: rtl/pdfb_src_tracker.sv
module pdfb_src_tracker #(
   parameter int SRC_W = 256,
   parameter int SRC_H = 240,
   localparam int XW   = $clog2(SRC_W+1),
   localparam int YW   = $clog2(SRC_H+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          sof,
   input  logic          eol,
   output logic [XW-1:0] pos_x,
   output logic [YW-1:0] pos_y,
   output logic          drop
);

   logic [XW-1:0] col_q;
   logic [YW-1:0] row_q;
   logic          col_out, row_out;

   // Position of the pixel now on the input; start-of-frame overrides.
   assign pos_x   = sof ? '0 : col_q;
   assign pos_y   = sof ? '0 : row_q;
   assign col_out = (pos_x >= XW'(SRC_W));
   assign row_out = (pos_y >= YW'(SRC_H));
   assign drop    = col_out || row_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (accept) begin
         if (eol) begin
            col_q <= '0;
            row_q <= row_out ? pos_y : pos_y + 1'b1;
         end else begin
            col_q <= col_out ? pos_x : pos_x + 1'b1;
            row_q <= pos_y;
         end
      end
   end

   // R8: the row count saturates at the picture height
   assert_row_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      row_q <= YW'(SRC_H));

   // R9: the column count saturates at the picture width
   assert_col_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= XW'(SRC_W));

   // R7: an accepted end-of-line returns the column to zero
   assert_eol_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && eol) |=> (col_q == '0));

endmodule

// File: rtl/pdfb_quad_emitter.sv
module pdfb_quad_emitter
   import pdfb_pkg::*;
#(
   parameter int AW          = 19,
   parameter int DATA_W      = 32,
   parameter int LINE_STRIDE = 1024,
   parameter int H_OFFSET    = 64,
   parameter int XW          = 9,
   parameter int YW          = 8,
   localparam int STRIDE_LG  = $clog2(LINE_STRIDE),
   localparam bit STRIDE_P2  = ((1 << STRIDE_LG) == LINE_STRIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [XW-1:0]     pos_x,
   input  logic [YW-1:0]     pos_y,
   input  logic [DATA_W-1:0] pix,
   output logic              busy,
   output logic              last,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   quad_e             phase_q;
   logic              busy_q;
   logic [AW-1:0]     base_q;
   logic [DATA_W-1:0] data_q;
   logic [AW-1:0]     row_off, col_off;
   logic [1:0]        ph;

   // Offset of output row 2*pos_y: a shift when the stride is a power of two.
   if (STRIDE_P2) begin : g_row_shift
      assign row_off = AW'(pos_y) << (STRIDE_LG + 1);
   end else begin : g_row_mult
      assign row_off = AW'(pos_y) * AW'(2*LINE_STRIDE);
   end

   assign col_off = AW'(H_OFFSET) + (AW'(pos_x) << 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= Q_TL;
         base_q  <= '0;
         data_q  <= '0;
      end else if (load) begin
         busy_q  <= 1'b1;
         phase_q <= Q_TL;
         base_q  <= row_off + col_off;
         data_q  <= pix;
      end else if (busy_q) begin
         if (phase_q == Q_BR)
            busy_q <= 1'b0;
         else
            phase_q <= quad_e'(phase_q + 2'd1);
      end
   end

   assign ph      = phase_q;
   assign busy    = busy_q;
   assign last    = busy_q && (phase_q == Q_BR);
   assign wr_addr = base_q + (ph[1] ? AW'(LINE_STRIDE) : '0) + AW'(ph[0]);
   assign wr_data = data_q;

   // R3: the four writes of one pixel follow each other without a gap
   assert_quad_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && phase_q != Q_BR && !load) |=>
         (busy_q && 2'(phase_q) == 2'($past(phase_q) + 2'd1)));

   // R5: a new pixel only arrives when the current quad is idle or finishing
   assert_load_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!busy_q || phase_q == Q_BR));

   // R3: the pixel value is held unchanged across its quad
   assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && phase_q != Q_BR && !load) |=> $stable(data_q));

endmodule

// File: rtl/pixdbl_fb_writer.sv
module pixdbl_fb_writer #(
   parameter int SRC_W       = 256,
   parameter int SRC_H       = 240,
   parameter int DISP_W      = 640,
   parameter int DISP_H      = 480,
   parameter int LINE_STRIDE = 1024,
   parameter int FB_LINES    = 512,
   parameter int H_OFFSET    = 64,
   parameter int DATA_W      = 32,
   localparam int DEPTH      = LINE_STRIDE * FB_LINES,
   localparam int AW         = $clog2(DEPTH),
   localparam int XW         = $clog2(SRC_W+1),
   localparam int YW         = $clog2(SRC_H+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sof,
   input  logic              in_eol,
   input  logic [DATA_W-1:0] in_rgb,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   // Elaboration-time checks of the parameter set.
   if (H_OFFSET + 2*SRC_W > DISP_W) begin : g_bad_width
      $error("scaled picture does not fit the display width");
   end
   if (DISP_W > LINE_STRIDE) begin : g_bad_stride
      $error("display width exceeds the line stride");
   end
   if (2*SRC_H > DISP_H || DISP_H > FB_LINES) begin : g_bad_height
      $error("scaled picture or display height exceeds the framebuffer");
   end

   logic              clr_done;
   logic [AW-1:0]     clr_addr;
   logic              accept, load, drop;
   logic [XW-1:0]     pos_x;
   logic [YW-1:0]     pos_y;
   logic              emit_busy, emit_last;
   logic [AW-1:0]     emit_addr;
   logic [DATA_W-1:0] emit_data;

   pdfb_clear_seq #(.DEPTH(DEPTH)) u_clear (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_done (clr_done),
      .clr_addr (clr_addr)
   );

   pdfb_src_tracker #(.SRC_W(SRC_W), .SRC_H(SRC_H)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .sof    (in_sof),
      .eol    (in_eol),
      .pos_x  (pos_x),
      .pos_y  (pos_y),
      .drop   (drop)
   );

   pdfb_quad_emitter #(
      .AW          (AW),
      .DATA_W      (DATA_W),
      .LINE_STRIDE (LINE_STRIDE),
      .H_OFFSET    (H_OFFSET),
      .XW          (XW),
      .YW          (YW)
   ) u_emit (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .pos_x   (pos_x),
      .pos_y   (pos_y),
      .pix     (in_rgb),
      .busy    (emit_busy),
      .last    (emit_last),
      .wr_addr (emit_addr),
      .wr_data (emit_data)
   );

   assign in_ready = clr_done && (!emit_busy || emit_last);
   assign accept   = in_valid && in_ready;
   assign load     = accept && !drop;

   assign wr_en    = !clr_done || emit_busy;
   assign wr_addr  = clr_done ? emit_addr : clr_addr;
   assign wr_data  = clr_done ? emit_data : '0;

   // R2: a pixel is only taken after the clear counter has reached the top
   assert_accept_after_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (clr_addr == AW'(DEPTH-1)));

   // R1: clear writes carry black
   assert_clear_black_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_done) |-> (wr_data == '0));

   // R4: pixel writes stay inside the centred column band
   assert_col_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr_done) |->
         ((int'(wr_addr) % LINE_STRIDE) >= H_OFFSET &&
          (int'(wr_addr) % LINE_STRIDE) <  H_OFFSET + 2*SRC_W));

   // R8/R9: a dropped pixel starts no write in the following cycle
   assert_drop_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && drop && !emit_busy) |=> !wr_en);

endmodule

// File: tb/pixdbl_fb_writer_test.sv
`timescale 1ns/1ps
module pixdbl_fb_writer_test;

   localparam int SW    = 8;
   localparam int SH    = 4;
   localparam int DSW   = 24;
   localparam int DSH   = 8;
   localparam int ST    = 32;
   localparam int FL    = 16;
   localparam int OF    = 4;
   localparam int DEPTH = ST * FL;
   localparam int AW    = $clog2(DEPTH);

   // Stimulus table: sof, eol, expected source x/y, dropped, requirement.
   localparam int NV = 12;
   localparam int    V_SOF  [NV] = '{1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1};
   localparam int    V_EOL  [NV] = '{0, 0, 1, 0, 0, 1, 1, 1, 1, 0, 1, 0};
   localparam int    V_X    [NV] = '{0, 1, 2, 0, 0, 1, 0, 0, 0, 0, 0, 0};
   localparam int    V_Y    [NV] = '{0, 0, 0, 1, 0, 0, 1, 2, 3, 0, 0, 0};
   localparam int    V_DROP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
   localparam string V_REQ  [NV] = '{"R6", "R3", "R7", "R7", "R6", "R4",
                                     "R7", "R4", "R4", "R8", "R8", "R6"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sof = 1'b0;
   logic          in_eol = 1'b0;
   logic [31:0]   in_rgb = '0;
   logic          in_ready;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [31:0]   wr_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pixdbl_fb_writer #(
      .SRC_W(SW), .SRC_H(SH), .DISP_W(DSW), .DISP_H(DSH),
      .LINE_STRIDE(ST), .FB_LINES(FL), .H_OFFSET(OF), .DATA_W(32)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_sof(in_sof), .in_eol(in_eol), .in_rgb(in_rgb),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Offer one pixel; returns at the falling edge after it was taken.
   task automatic send(input bit sof, input bit eol, input logic [31:0] rgb);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_sof = sof; in_eol = eol; in_rgb = rgb;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
   endtask

   // Check the four writes of a pixel at (sx, sy); starts in the first write cycle.
   task automatic expect_quad(input int sx, input int sy, input logic [31:0] rgb,
                              input string req);
      for (int q = 0; q < 4; q++) begin
         int ea;
         if (q > 0) @(negedge clk);
         ea = (2*sy + q/2) * ST + OF + 2*sx + (q % 2);
         chk(wr_en == 1'b1, req, "write enable", wr_en, 1);
         chk(wr_addr == AW'(ea), req, "write address", wr_addr, ea);
         chk(wr_data == rgb, req, "write data", wr_data, rgb);
         chk(in_ready == (q == 3), "R5", "ready during quad", in_ready, (q == 3));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int bad_addr;
      int bad_data;
      int bad_rdy;
      logic [31:0] rgb;
      bad_addr = 0; bad_data = 0; bad_rdy = 0;

      // Reset state: clear already points at address 0 with black.
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R2", "ready in reset", in_ready, 0);
      chk(wr_en == 1'b1 && wr_addr == '0, "R1", "clear start address", wr_addr, 0);

      rst_n = 1'b1;
      // R1/R2: full clear sweep, one address per cycle, ready held low.
      for (int i = 0; i < DEPTH; i++) begin
         if (!wr_en || wr_addr != AW'(i)) bad_addr++;
         if (wr_data != '0) bad_data++;
         if (in_ready) bad_rdy++;
         @(negedge clk);
      end
      chk(bad_addr == 0, "R1", "clear address mismatches", bad_addr, 0);
      chk(bad_data == 0, "R1", "clear data mismatches", bad_data, 0);
      chk(bad_rdy == 0, "R2", "ready during clear", bad_rdy, 0);
      chk(in_ready == 1'b1, "R2", "ready after clear", in_ready, 1);
      chk(wr_en == 1'b0, "R10", "idle after clear", wr_en, 0);

      // Table of vectors.
      for (int v = 0; v < NV; v++) begin
         rgb = 32'h00A0_3000 + 32'(v) * 32'h0001_0101;
         send(V_SOF[v][0], V_EOL[v][0], rgb);
         if (V_DROP[v] != 0) begin
            chk(wr_en == 1'b0, V_REQ[v], "no write for dropped pixel", wr_en, 0);
            chk(in_ready == 1'b1, V_REQ[v], "ready after dropped pixel", in_ready, 1);
         end else begin
            expect_quad(V_X[v], V_Y[v], rgb, V_REQ[v]);
         end
      end

      // Columns 1..7 of row 0 (the table left the column at 1).
      for (int c = 1; c < SW; c++) begin
         rgb = 32'h0011_0000 + 32'(c);
         send(1'b0, 1'b0, rgb);
         expect_quad(c, 0, rgb, "R4");
      end
      // R9: column 8 is past the picture, twice; the second carries end-of-line.
      send(1'b0, 1'b0, 32'hDEAD_0001);
      chk(wr_en == 1'b0, "R9", "no write past last column", wr_en, 0);
      send(1'b0, 1'b1, 32'hDEAD_0002);
      chk(wr_en == 1'b0, "R9", "no write on dropped end-of-line", wr_en, 0);
      send(1'b0, 1'b0, 32'h0022_0000);
      expect_quad(0, 1, 32'h0022_0000, "R9");

      // R5: next pixel offered in the fourth write cycle is taken back to back.
      send(1'b0, 1'b0, 32'h0033_0001);
      expect_quad(1, 1, 32'h0033_0001, "R5");
      in_valid = 1'b1; in_rgb = 32'h0033_0002;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      expect_quad(2, 1, 32'h0033_0002, "R5");

      // R10: no write once the quad is over.
      @(negedge clk);
      chk(wr_en == 1'b0, "R10", "idle after quad", wr_en, 0);
      repeat (3) @(negedge clk);
      chk(wr_en == 1'b0, "R10", "idle while no input", wr_en, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule